// File: doc/BRIEF.md
# Keyed LSB Steganography Engine

The engine hides a 40-bit text message (five 8-bit characters) inside grayscale pixels held in an external synchronous single-port pixel memory, and it can later recover that message. Each message bit lands in the least significant bit of one pixel. A key-seeded pseudo-random sequence chooses that pixel, so the hidden bits are spread over the image instead of sitting in consecutive locations.

In embed mode the engine takes a message that was loaded in parallel while it was idle. It shifts the message out one bit at a time. For each bit it draws an unused pixel address, reads the pixel, replaces bit 0 and writes the pixel back to the same place. In extract mode it walks the same address sequence and gathers each pixel's bit 0 into a shift register that rebuilds the message. One central FSM drives the address generator, the serializer and the collector, and it produces a one-cycle done pulse at the end of each run.

Top module: `stego_lsb_engine`

## Requirements
- R1: While `rst` is high and after it is released, `done`, `mem_rd` and `mem_wr` are low and `msg_out` is zero.
- R2: An embed write changes only bit 0 of a pixel. `mem_wdata[7:1]` equals bits 7:1 of the pixel just read, and the write goes to the address of that read.
- R3: Message bits are used from `msg_in[39]` down to `msg_in[0]`, so character 0 sits in `msg_in[39:32]` and its MSB is used first.
- R4: The address sequence comes from a 16-bit Galois LFSR. The seed is `key`, or 16'hACE1 when `key` is zero. Each step shifts the state right by one and XORs in 16'hB400 when the bit shifted out was 1. The address is the low ADDR_W bits of the state after each step.
- R5: An address already used in the current run is skipped, so the 40 bits of one run occupy 40 distinct pixels.
- R6: A read (`mem_rd`) is followed by one cycle of read latency before the pixel is taken. A write happens in a separate cycle, and `mem_rd` and `mem_wr` are never high together.
- R7: Extraction with the key used for embedding returns the embedded message on `msg_out`. `msg_out` changes only during an extract run and holds its value across embed runs.
- R8: Extraction with a different key returns the bits found along that key's address sequence, which differ from the embedded message.
- R9: `done` is a one-cycle pulse after the 40th bit is written or captured, and the engine then returns to idle.
- R10: `start` and `msg_load` are ignored while a run is in progress.
- R11: Starting with `mode_embed` = 1 embeds. Starting with `mode_embed` = 0 extracts and issues no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_embed | input | 1 | 1 = embed, 0 = extract; sampled on start |
| start | input | 1 | Begins a run when idle |
| key | input | 16 | Stego key seeding the address sequence |
| msg_load | input | 1 | Parallel load of msg_in when idle |
| msg_in | input | 40 | Message to hide, character 0 in bits 39:32 |
| msg_out | output | 40 | Recovered message |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Pixel address |
| mem_rd | output | 1 | Pixel read request, data valid next cycle |
| mem_wr | output | 1 | Pixel write strobe |
| mem_wdata | output | 8 | Pixel write data |
| mem_rdata | input | 8 | Pixel read data |

## Verification
Random messages and keys are embedded into a random image. The whole memory is then compared with a bench model, which shows whether any bit other than bit 0 was touched, whether a pixel was reused, and whether the address sequence or bit order is wrong. Extracting with the same key checks the round trip. Extracting with a different key, and using a zero key, checks the key dependence and the seed substitution. A start pulse and a message load issued in the middle of a run show whether the engine ignores them while busy.

// File: rtl/stego_pkg.sv
package stego_pkg;
    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] LFSR_TAPS = 16'hB400;
    localparam logic [KEY_W-1:0] ZERO_KEY_SEED = 16'hACE1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_STEP, ST_PICK, ST_READ, ST_WAIT, ST_WRITE, ST_FIN, ST_DONE
    } ctl_state_e;

    function automatic logic [KEY_W-1:0] lfsr_advance(input logic [KEY_W-1:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
    endfunction
endpackage

// File: rtl/stego_addr_gen.sv
module stego_addr_gen #(
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       seed_load,
    input  logic [stego_pkg::KEY_W-1:0] seed,
    input  logic                       step,
    input  logic                       mark,
    output logic [ADDR_W-1:0]          addr,
    output logic                       addr_used
);
    import stego_pkg::*;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [KEY_W-1:0] lfsr;
        logic [DEPTH-1:0] used;
    } gen_regs_t;

    gen_regs_t r_d, r_q;

    assign addr      = r_q.lfsr[ADDR_W-1:0];
    assign addr_used = r_q.used[addr];

    always_comb begin
        r_d = r_q;
        if (seed_load) begin
            r_d.lfsr = (seed == '0) ? ZERO_KEY_SEED : seed;
            r_d.used = '0;
        end else begin
            if (step) r_d.lfsr = lfsr_advance(r_q.lfsr);
            if (mark) r_d.used[addr] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.lfsr <= ZERO_KEY_SEED;
            r_q.used <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R5: a pixel is claimed only if it is still free in this run
    p_mark_fresh_r5: assert property (@(posedge clk) disable iff (rst)
        mark |-> !r_q.used[addr]);
    // R4: a maximal-length LFSR never reaches the all-zero state
    p_lfsr_live_r4: assert property (@(posedge clk) disable iff (rst)
        r_q.lfsr != '0);
endmodule

// File: rtl/stego_serializer.sv
module stego_serializer #(
    parameter int MSG_BITS = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [MSG_BITS-1:0] din,
    input  logic                shift,
    output logic                bit_o
);
    logic [MSG_BITS-1:0] sh_d, sh_q;

    assign bit_o = sh_q[MSG_BITS-1];

    always_comb begin
        sh_d = sh_q;
        if (load)       sh_d = din;
        else if (shift) sh_d = {sh_q[MSG_BITS-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end
endmodule

// File: rtl/stego_collector.sv
module stego_collector #(
    parameter int MSG_BITS = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                en,
    input  logic                bit_i,
    output logic [MSG_BITS-1:0] dout
);
    logic [MSG_BITS-1:0] col_d, col_q;

    assign dout = col_q;

    always_comb begin
        col_d = col_q;
        if (clr)     col_d = '0;
        else if (en) col_d = {col_q[MSG_BITS-2:0], bit_i};
    end

    always_ff @(posedge clk) begin
        if (rst) col_q <= '0;
        else     col_q <= col_d;
    end

    // R7: the recovered word moves only on a capture or a clear
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(en) && !$past(clr)) |-> $stable(col_q));
endmodule

// File: rtl/stego_lsb_engine.sv
module stego_lsb_engine #(
    parameter int ADDR_W   = 8,
    parameter int PIX_W    = 8,
    parameter int MSG_BITS = 40
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        mode_embed,
    input  logic                        start,
    input  logic [stego_pkg::KEY_W-1:0] key,
    input  logic                        msg_load,
    input  logic [MSG_BITS-1:0]         msg_in,
    output logic [MSG_BITS-1:0]         msg_out,
    output logic                        done,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic                        mem_rd,
    output logic                        mem_wr,
    output logic [PIX_W-1:0]            mem_wdata,
    input  logic [PIX_W-1:0]            mem_rdata
);
    import stego_pkg::*;
    localparam int CNT_W = $clog2(MSG_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(MSG_BITS - 1);

    typedef struct packed {
        ctl_state_e       st;
        logic             embed;
        logic [CNT_W-1:0] cnt;
        logic [PIX_W-1:0] pix;
    } ctl_regs_t;

    ctl_regs_t c_d, c_q;

    logic gen_seed, gen_step, gen_mark, gen_used;
    logic ser_load, ser_shift, ser_bit;
    logic col_clr, col_en;
    logic [ADDR_W-1:0] gen_addr;

    stego_addr_gen #(.ADDR_W(ADDR_W)) u_gen (
        .clk(clk), .rst(rst), .seed_load(gen_seed), .seed(key),
        .step(gen_step), .mark(gen_mark), .addr(gen_addr), .addr_used(gen_used)
    );

    stego_serializer #(.MSG_BITS(MSG_BITS)) u_ser (
        .clk(clk), .rst(rst), .load(ser_load), .din(msg_in),
        .shift(ser_shift), .bit_o(ser_bit)
    );

    stego_collector #(.MSG_BITS(MSG_BITS)) u_col (
        .clk(clk), .rst(rst), .clr(col_clr), .en(col_en),
        .bit_i(mem_rdata[0]), .dout(msg_out)
    );

    assign mem_addr = gen_addr;

    always_comb begin
        c_d       = c_q;
        gen_seed  = 1'b0;
        gen_step  = 1'b0;
        gen_mark  = 1'b0;
        ser_load  = 1'b0;
        ser_shift = 1'b0;
        col_clr   = 1'b0;
        col_en    = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = {c_q.pix[PIX_W-1:1], ser_bit};
        done      = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    gen_seed = 1'b1;
                    col_clr  = !mode_embed;
                    c_d.embed = mode_embed;
                    c_d.cnt   = '0;
                    c_d.st    = ST_STEP;
                end else if (msg_load) begin
                    ser_load = 1'b1;
                end
            end
            ST_STEP: begin
                gen_step = 1'b1;
                c_d.st   = ST_PICK;
            end
            ST_PICK: begin
                if (gen_used) begin
                    c_d.st = ST_STEP;
                end else begin
                    gen_mark = 1'b1;
                    c_d.st   = ST_READ;
                end
            end
            ST_READ: begin
                mem_rd = 1'b1;
                c_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                c_d.pix = mem_rdata;
                if (c_q.embed) begin
                    c_d.st = ST_WRITE;
                end else begin
                    col_en = 1'b1;
                    c_d.st = ST_FIN;
                end
            end
            ST_WRITE: begin
                mem_wr    = 1'b1;
                ser_shift = 1'b1;
                c_d.st    = ST_FIN;
            end
            ST_FIN: begin
                if (c_q.cnt == LAST_BIT) begin
                    c_d.st = ST_DONE;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                    c_d.st  = ST_STEP;
                end
            end
            ST_DONE: begin
                done   = 1'b1;
                c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.st    <= ST_IDLE;
            c_q.embed <= 1'b0;
            c_q.cnt   <= '0;
            c_q.pix   <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    // R6: the memory port never reads and writes in one cycle
    p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    // R2: the write hits the address read two cycles earlier
    p_same_addr_r2: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> ($past(mem_rd, 2) && mem_addr == $past(mem_addr, 2)));
    // R2: only bit 0 differs from the pixel that was fetched
    p_upper_kept_r2: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_wdata[PIX_W-1:1] == $past(mem_rdata[PIX_W-1:1])));
    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R11: an extract run never writes
    p_extract_nowrite_r11: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> c_q.embed);
    // R1: reset leaves the memory port quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!mem_rd && !mem_wr && !done));
endmodule

// File: tb/sim_stego_lsb_engine.sv
module sim_stego_lsb_engine;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int MSG_BITS = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_embed = 1'b0, start = 1'b0, msg_load = 1'b0;
    logic [15:0] key = '0;
    logic [MSG_BITS-1:0] msg_in = '0, msg_out;
    logic done, mem_rd, mem_wr;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;

    logic [7:0] mem [DEPTH];
    logic [7:0] exp_mem [DEPTH];
    int checks = 0, errors = 0, cycles = 0, done_cnt = 0, wr_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stego_lsb_engine #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .mode_embed(mode_embed), .start(start), .key(key),
        .msg_load(msg_load), .msg_in(msg_in), .msg_out(msg_out), .done(done),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    always @(negedge clk) begin
        cycles++;
        if (done) done_cnt++;
        if (mem_wr) wr_cnt++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [15:0] nxt(input logic [15:0] s);
        return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
    endfunction

    // Model address list per R4/R5, then embed per R2/R3 or extract per R7
    task automatic model_embed(input logic [15:0] k, input logic [MSG_BITS-1:0] m);
        logic [15:0] s;
        bit used [DEPTH];
        s = (k == 0) ? 16'hACE1 : k;
        foreach (used[i]) used[i] = 0;
        for (int b = MSG_BITS-1; b >= 0; b--) begin
            do s = nxt(s); while (used[s[ADDR_W-1:0]]);
            used[s[ADDR_W-1:0]] = 1;
            exp_mem[s[ADDR_W-1:0]][0] = m[b];
        end
    endtask

    function automatic logic [MSG_BITS-1:0] model_extract(input logic [15:0] k);
        logic [15:0] s;
        bit used [DEPTH];
        logic [MSG_BITS-1:0] r;
        s = (k == 0) ? 16'hACE1 : k;
        r = '0;
        foreach (used[i]) used[i] = 0;
        for (int b = 0; b < MSG_BITS; b++) begin
            do s = nxt(s); while (used[s[ADDR_W-1:0]]);
            used[s[ADDR_W-1:0]] = 1;
            r = {r[MSG_BITS-2:0], exp_mem[s[ADDR_W-1:0]][0]};
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_msg(input logic [MSG_BITS-1:0] m);
        @(negedge clk); msg_in = m; msg_load = 1'b1;
        @(negedge clk); msg_load = 1'b0;
    endtask

    // Starts a run; optionally disturbs it mid-way with start and a load (R10)
    task automatic run_op(input bit emb, input logic [15:0] k, input bit disturb);
        int d0, w0, n;
        d0 = done_cnt; w0 = wr_cnt; n = 0;
        @(negedge clk); mode_embed = emb; key = k; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (disturb) begin
            repeat (30) @(negedge clk);
            start = 1'b1; msg_load = 1'b1; msg_in = ~msg_in; mode_embed = ~emb;
            @(negedge clk); start = 1'b0; msg_load = 1'b0;
        end
        while (done_cnt == d0 && n < 5000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
        check(done_cnt == d0 + 1, "R9 done pulses", 64'(done_cnt - d0), 64'd1);
        check(wr_cnt - w0 == (emb ? MSG_BITS : 0), "R11/R5 write count",
              64'(wr_cnt - w0), emb ? 64'(MSG_BITS) : 64'd0);
    endtask

    task automatic compare_mem(input string req);
        int bad;
        bad = 0;
        foreach (mem[i]) if (mem[i] !== exp_mem[i]) bad++;
        check(bad == 0, req, 64'(bad), 64'd0);
    endtask

    initial begin
        logic [MSG_BITS-1:0] m, prev, got;
        logic [15:0] k, k2;
        void'($urandom(32'd1701));
        foreach (mem[i]) begin mem[i] = 8'($urandom); exp_mem[i] = mem[i]; end
        repeat (4) @(negedge clk);
        check(!done && !mem_rd && !mem_wr && msg_out == '0, "R1 reset state",
              64'(msg_out), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !mem_rd && !mem_wr && msg_out == '0, "R1 after release",
              64'(msg_out), 64'd0);

        // Directed: character string, key 16'h04E6
        m = {8'h61, 8'h62, 8'h63, 8'h64, 8'h65};
        k = 16'h04E6;
        load_msg(m);
        run_op(1'b1, k, 1'b0);
        model_embed(k, m);
        compare_mem("R2/R3/R4/R5 embedded image");
        check(msg_out == '0, "R7 msg_out held across embed", 64'(msg_out), 64'd0);
        run_op(1'b0, k, 1'b0);
        check(msg_out == m, "R7 round trip", 64'(msg_out), 64'(m));
        compare_mem("R11 extract leaves image");

        // Wrong key
        k2 = 16'h0856;
        run_op(1'b0, k2, 1'b0);
        got = model_extract(k2);
        check(msg_out == got, "R8 wrong-key bits", 64'(msg_out), 64'(got));
        check(msg_out != m, "R8 wrong key differs", 64'(msg_out), 64'(m));

        // Zero key uses the fixed seed
        m = {8'h4C, 8'h49, 8'h47, 8'h48, 8'h54};
        load_msg(m);
        run_op(1'b1, 16'h0000, 1'b0);
        model_embed(16'h0000, m);
        compare_mem("R4 zero key image");
        run_op(1'b0, 16'hACE1, 1'b0);
        check(msg_out == m, "R4 zero key equals fixed seed", 64'(msg_out), 64'(m));

        // Busy run disturbed by start and load
        m = 40'hF0_0F_AA_55_C3;
        k = 16'h1234;
        load_msg(m);
        run_op(1'b1, k, 1'b1);
        model_embed(k, m);
        compare_mem("R10 image after disturbed embed");
        prev = msg_out;
        run_op(1'b0, k, 1'b1);
        check(msg_out == m, "R10 disturbed extract", 64'(msg_out), 64'(m));

        // Edge patterns: all ones, all zeros
        m = '1; k = 16'hFFFF;
        load_msg(m);
        run_op(1'b1, k, 1'b0);
        model_embed(k, m);
        compare_mem("R3 all-ones image");
        check(msg_out == prev ^ prev ^ 40'hF0_0F_AA_55_C3, "R7 held after embed",
              64'(msg_out), 64'h00F00FAA55C3);
        run_op(1'b0, k, 1'b0);
        check(msg_out == m, "R7 all-ones round trip", 64'(msg_out), 64'(m));

        // Random mix
        for (int it = 0; it < 12; it++) begin
            m = {8'($urandom), 32'($urandom)};
            k = 16'($urandom);
            load_msg(m);
            run_op(1'b1, k, 1'b0);
            model_embed(k, m);
            compare_mem("R2/R5 random image");
            run_op(1'b0, k, 1'b0);
            check(msg_out == m, "R7 random round trip", 64'(msg_out), 64'(m));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule